// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a parameterised set of general event counters and one dedicated cycle counter, all reached through a simple register port: a write strobe, an 8-bit address, a 64-bit write word and a combinational 64-bit read word. Each general counter has a type register that picks its event source. The source can be one of several multi-count event inputs (each input carries a small count per clock), the fixed core-cycle event, or a software-increment pseudo-event that firmware pulses with a bitmask write.

Counting is gated by a global enable and a per-counter enable mask, in which the cycle counter owns bit 31. Every increment is compared against the headroom that is left before the counter wraps, at 32 or 64 bits. When an increment exceeds that headroom, the counter's sticky overflow-status bit is set. A single level interrupt is raised whenever a set status bit is also enabled in the interrupt mask. The cycle counter can be slowed to one step every 64 enabled clocks by using a carried 6-bit remainder.

Register map (8-bit address):
- `0x00` control:
  - bit0 global enable
  - bit1 cycle-counter clear (pulse)
  - bit2 general-counter clear (pulse)
  - bit3 divide-by-64 mode
  - bit4 cycle-counter 64-bit overflow mode
- `0x01` count-enable mask
- `0x02` interrupt-enable mask
- `0x03` overflow status
- `0x04` software increment
- `0x05` event-availability bitmap
- `0x06` cycle counter (64-bit)
- `0x07` cycle counter low word
- `0x10+i` counter i value
- `0x30+i` counter i type:
  - bits[7:0] event ID
  - bit8 64-bit overflow mode

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter, type register, mask, status bit and control bit reads as zero, and irq_o is low.
- R2: General counter i advances only while control bit0 and count-enable bit i are both set; the cycle counter uses count-enable bit 31. Only bits 0..NUM_CNT-1 and 31 of the enable and interrupt masks are writable.
- R3: A counter whose type ID is k in 1..NUM_EVT adds the EVT_W-bit count on event input k-1 each enabled clock. ID 0x11 adds 1 per enabled clock. Any other ID except 0x00 adds nothing.
- R4: A write to 0x04 adds 1 to every enabled counter whose type ID is 0x00 and whose bit is set in the written value; other counters are unaffected by it.
- R5: Overflow occurs when the increment exceeds the headroom before wrap, which is 2^32-1 minus the low word or, in 64-bit mode (type bit8, or control bit4 for the cycle counter), 2^64-1 minus the value. On overflow, status bit i (bit 31 for the cycle counter) is set and the counter wraps.
- R6: Overflow-status bits are sticky and cleared by writing 1 to them at 0x03; a set in the same cycle wins over the clear.
- R7: irq_o is high exactly when some overflow-status bit is set together with its interrupt-enable bit.
- R8: With control bit3 set, the cycle counter advances by 1 once every 64 enabled clocks via a 6-bit remainder; any write that changes bit3 clears the remainder.
- R9: A control write with bit1 set clears the cycle counter; with bit2 set it clears all general counters; the increment of that cycle is discarded.
- R10: A write to a counter value (0x10+i, or 0x06 for the cycle counter) takes the written value and discards any increment of the same cycle.
- R11: Writing a type register with a different event ID clears that counter; rewriting the same ID keeps its value.
- R12: Address 0x05 reads a read-only bitmap with bit 0, bits 1..NUM_EVT and bit 17 set; writes to it change nothing.
- R13: Reads of 0x10+i and 0x07 return only the low 32 bits, zero-extended; 0x06 returns all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| evt_bus | input | NUM_EVT*EVT_W | Per-clock counts of the event inputs, input k in bits [k*EVT_W +: EVT_W] |
| irq_o | output | 1 | Level interrupt |

## Verification
Random multi-bit counts on all event inputs separate the per-ID source selection from inputs that are merely present. Counters that are disabled, or set to an unsupported ID, must stay still while the same stimulus moves their neighbours. Software-increment masks that also hit counters set to other IDs show that only pseudo-event counters react. Values preloaded just below the 32-bit and 64-bit wrap points tell the two overflow modes apart, including a long-mode counter that crosses 2^32 without flagging. Long divide-by-64 runs, with a mode toggle in the middle, show the remainder being kept and then cleared.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam logic [7:0] ADDR_CTL      = 8'h00;
    localparam logic [7:0] ADDR_CEN      = 8'h01;
    localparam logic [7:0] ADDR_IEN      = 8'h02;
    localparam logic [7:0] ADDR_OVF      = 8'h03;
    localparam logic [7:0] ADDR_SWINC    = 8'h04;
    localparam logic [7:0] ADDR_AVAIL    = 8'h05;
    localparam logic [7:0] ADDR_CYC      = 8'h06;
    localparam logic [7:0] ADDR_CYC_LO   = 8'h07;
    localparam logic [7:0] ADDR_CNT_BASE = 8'h10;
    localparam logic [7:0] ADDR_TYP_BASE = 8'h30;

    localparam int CTL_EN      = 0;
    localparam int CTL_CYC_CLR = 1;
    localparam int CTL_GEN_CLR = 2;
    localparam int CTL_DIV     = 3;
    localparam int CTL_CLONG   = 4;

    localparam int TYP_LONG    = 8;
    localparam int CYC_BIT     = 31;
    localparam int DIV_SHIFT   = 6;
    localparam int MAX_CNT     = 31;

    localparam logic [7:0] EVT_SWINC = 8'h00;
    localparam logic [7:0] EVT_CYCLE = 8'h11;

    function automatic logic [31:0] valid_mask(input int num_cnt);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < num_cnt; k++) m[k] = 1'b1;
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] avail_map(input int num_evt);
        logic [31:0] m;
        m = '0;
        m[EVT_SWINC[4:0]] = 1'b1;
        for (int k = 1; k <= num_evt; k++) m[k] = 1'b1;
        m[EVT_CYCLE[4:0]] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pmc_event_select.sv
module pmc_event_select #(
    parameter int NUM_EVT = 8,
    parameter int EVT_W   = 4
) (
    input  logic [7:0]               evt_id,
    input  logic [NUM_EVT*EVT_W-1:0] evt_bus,
    input  logic                     sw_hit,
    output logic [EVT_W-1:0]         delta
);
    import pmc_pkg::*;

    always_comb begin
        delta = '0;
        if (evt_id == EVT_SWINC) begin
            delta = EVT_W'(sw_hit);
        end else if (evt_id == EVT_CYCLE) begin
            delta = EVT_W'(1);
        end else begin
            for (int k = 0; k < NUM_EVT; k++) begin
                if (evt_id == 8'(k + 1)) delta = evt_bus[k*EVT_W +: EVT_W];
            end
        end
    end
endmodule

// File: rtl/pmc_counter_slice.sv
module pmc_counter_slice #(
    parameter int DELTA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [DELTA_W-1:0] delta_i,
    input  logic               long_i,
    input  logic               load_i,
    input  logic [63:0]        load_val_i,
    input  logic               clr_i,
    output logic [63:0]        value_o,
    output logic               ovf_o
);
    logic [63:0] value_q;
    logic        over_long;
    logic        over_short;

    // headroom comparison: increment larger than distance to wrap
    assign over_long  = 64'(delta_i) > ~value_q;
    assign over_short = 32'(delta_i) > ~value_q[31:0];
    assign ovf_o      = en_i && !load_i && !clr_i && (long_i ? over_long : over_short);
    assign value_o    = value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load_i) begin
            value_q <= load_val_i;
        end else if (clr_i) begin
            value_q <= '0;
        end else if (en_i) begin
            value_q <= value_q + 64'(delta_i);
        end
    end
endmodule

// File: rtl/pmc_cycle_prescale.sv
module pmc_cycle_prescale #(
    parameter int SHIFT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic div_i,
    input  logic clr_rem_i,
    output logic step_o
);
    logic [SHIFT-1:0] rem_q;

    assign step_o = tick_en && (!div_i || (&rem_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clr_rem_i) begin
            rem_q <= '0;
        end else if (tick_en && div_i) begin
            rem_q <= rem_q + SHIFT'(1);
        end
    end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank #(
    parameter int NUM_CNT = 4,
    parameter int NUM_EVT = 8,
    parameter int EVT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [7:0]               reg_addr,
    input  logic [63:0]              reg_wdata,
    output logic [63:0]              reg_rdata,
    input  logic [NUM_EVT*EVT_W-1:0] evt_bus,
    output logic                     irq_o
);
    import pmc_pkg::*;

    localparam logic [31:0] MASK_OK  = valid_mask(NUM_CNT);
    localparam logic [31:0] AVAIL    = avail_map(NUM_EVT);

    logic        gen_en_q, div_q, cyc_long_q;
    logic [31:0] cen_q, ien_q, ovf_q, ovf_set;
    logic [7:0]  typ_id_q [NUM_CNT];
    logic [NUM_CNT-1:0] typ_long_q;

    logic [63:0] cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0] gen_ovf;
    logic [63:0] cyc_val;
    logic        cyc_ovf, cyc_step;

    logic wr_ctl, wr_cen, wr_ien, wr_ovf, wr_swinc, wr_cyc;
    logic [NUM_CNT-1:0] wr_cnt, wr_typ;

    assign wr_ctl   = reg_we && (reg_addr == ADDR_CTL);
    assign wr_cen   = reg_we && (reg_addr == ADDR_CEN);
    assign wr_ien   = reg_we && (reg_addr == ADDR_IEN);
    assign wr_ovf   = reg_we && (reg_addr == ADDR_OVF);
    assign wr_swinc = reg_we && (reg_addr == ADDR_SWINC);
    assign wr_cyc   = reg_we && (reg_addr == ADDR_CYC);

    // general counters
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [EVT_W-1:0] delta;
        logic             clr;

        assign wr_cnt[i] = reg_we && (reg_addr == ADDR_CNT_BASE + 8'(i));
        assign wr_typ[i] = reg_we && (reg_addr == ADDR_TYP_BASE + 8'(i));
        assign clr = (wr_ctl && reg_wdata[CTL_GEN_CLR])
                  || (wr_typ[i] && (reg_wdata[7:0] != typ_id_q[i]));

        pmc_event_select #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) sel_i (
            .evt_id  (typ_id_q[i]),
            .evt_bus (evt_bus),
            .sw_hit  (wr_swinc && reg_wdata[i]),
            .delta   (delta)
        );

        pmc_counter_slice #(.DELTA_W(EVT_W)) slice_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (gen_en_q && cen_q[i]),
            .delta_i    (delta),
            .long_i     (typ_long_q[i]),
            .load_i     (wr_cnt[i]),
            .load_val_i (reg_wdata),
            .clr_i      (clr),
            .value_o    (cnt_val[i]),
            .ovf_o      (gen_ovf[i])
        );
    end

    // cycle counter
    pmc_cycle_prescale #(.SHIFT(DIV_SHIFT)) pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (gen_en_q && cen_q[CYC_BIT]),
        .div_i     (div_q),
        .clr_rem_i (wr_ctl && (reg_wdata[CTL_DIV] != div_q)),
        .step_o    (cyc_step)
    );

    pmc_counter_slice #(.DELTA_W(1)) cyc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cyc_step),
        .delta_i    (1'b1),
        .long_i     (cyc_long_q),
        .load_i     (wr_cyc),
        .load_val_i (reg_wdata),
        .clr_i      (wr_ctl && reg_wdata[CTL_CYC_CLR]),
        .value_o    (cyc_val),
        .ovf_o      (cyc_ovf)
    );

    always_comb begin
        ovf_set = '0;
        for (int i = 0; i < NUM_CNT; i++) ovf_set[i] = gen_ovf[i];
        ovf_set[CYC_BIT] = cyc_ovf;
    end

    // configuration and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en_q   <= 1'b0;
            div_q      <= 1'b0;
            cyc_long_q <= 1'b0;
            cen_q      <= '0;
            ien_q      <= '0;
            ovf_q      <= '0;
            typ_long_q <= '0;
            for (int i = 0; i < NUM_CNT; i++) typ_id_q[i] <= '0;
        end else begin
            if (wr_ctl) begin
                gen_en_q   <= reg_wdata[CTL_EN];
                div_q      <= reg_wdata[CTL_DIV];
                cyc_long_q <= reg_wdata[CTL_CLONG];
            end
            if (wr_cen) cen_q <= reg_wdata[31:0] & MASK_OK;
            if (wr_ien) ien_q <= reg_wdata[31:0] & MASK_OK;
            ovf_q <= (ovf_q & ~(wr_ovf ? reg_wdata[31:0] : 32'h0)) | ovf_set;
            for (int i = 0; i < NUM_CNT; i++) begin
                if (wr_typ[i]) begin
                    typ_id_q[i]   <= reg_wdata[7:0];
                    typ_long_q[i] <= reg_wdata[TYP_LONG];
                end
            end
        end
    end

    assign irq_o = |(ovf_q & ien_q);

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTL:    reg_rdata = 64'({cyc_long_q, div_q, 2'b00, gen_en_q});
            ADDR_CEN:    reg_rdata = 64'(cen_q);
            ADDR_IEN:    reg_rdata = 64'(ien_q);
            ADDR_OVF:    reg_rdata = 64'(ovf_q);
            ADDR_AVAIL:  reg_rdata = 64'(AVAIL);
            ADDR_CYC:    reg_rdata = cyc_val;
            ADDR_CYC_LO: reg_rdata = 64'(cyc_val[31:0]);
            default: begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (reg_addr == ADDR_CNT_BASE + 8'(i))
                        reg_rdata = 64'(cnt_val[i][31:0]);
                    if (reg_addr == ADDR_TYP_BASE + 8'(i))
                        reg_rdata = 64'({typ_long_q[i], typ_id_q[i]});
                end
            end
        endcase
    end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int NUM_CNT = 4,
    parameter int NUM_EVT = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [63:0] reg_wdata,
    input logic        irq_o,
    input logic        gen_en_q,
    input logic [31:0] ovf_q,
    input logic [63:0] cnt0,
    input logic [63:0] cyc_val
);
    import pmc_pkg::*;

    initial begin
        assert_param_range_R2: assert (NUM_CNT >= 1 && NUM_CNT <= MAX_CNT && NUM_EVT >= 1 && NUM_EVT <= 16)
            else $error("counter bank parameters out of range");
    end

    assert_value_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_CNT_BASE) |=> (cnt0 == $past(reg_wdata)));

    assert_cycle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_CTL && reg_wdata[CTL_CYC_CLR]) |=> (cyc_val == 64'd0));

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q[0] && !(reg_we && reg_addr == ADDR_OVF && reg_wdata[0])) |=> ovf_q[0]);

    assert_cycle_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q[CYC_BIT] && !(reg_we && reg_addr == ADDR_OVF && reg_wdata[CYC_BIT])) |=> ovf_q[CYC_BIT]);

    assert_hold_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en_q && !reg_we) |=> (cnt0 == $past(cnt0)));

    assert_irq_needs_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf_q != 32'd0));
endmodule

bind pmc_bank pmc_checker #(.NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .gen_en_q  (gen_en_q),
    .ovf_q     (ovf_q),
    .cnt0      (cnt_val[0]),
    .cyc_val   (cyc_val)
);

// File: tb/pmc_bank_tb_top.sv
`timescale 1ns/1ps
module pmc_bank_tb_top;
    localparam int NC = 4;
    localparam int NE = 8;
    localparam int EW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [7:0] addr = '0;
    logic [63:0] wd = '0;
    logic [63:0] rd;
    logic [NE*EW-1:0] evt = '0;
    logic irq;

    always #2.5 clk = ~clk;

    pmc_bank #(.NUM_CNT(NC), .NUM_EVT(NE), .EVT_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wd),
        .reg_rdata(rd), .evt_bus(evt), .irq_o(irq)
    );

    // behavioural reference model
    longint unsigned m_cnt [NC];
    longint unsigned m_cyc;
    int              m_id  [NC];
    bit              m_lng [NC];
    bit              m_gen, m_div, m_clong;
    bit [31:0]       m_cen, m_ien, m_ovf;
    int              m_rem;
    int n_chk = 0, n_fail = 0;
    int unsigned seed = 32'h1234_5678;
    bit [31:0] okmask = 32'h8000_000F;

    function automatic logic [63:0] mread(input logic [7:0] a);
        if (a == 8'h00) return 64'({m_clong, m_div, 2'b00, m_gen});
        if (a == 8'h01) return 64'(m_cen);
        if (a == 8'h02) return 64'(m_ien);
        if (a == 8'h03) return 64'(m_ovf);
        if (a == 8'h05) return 64'h0000_0000_0002_01FF;
        if (a == 8'h06) return m_cyc;
        if (a == 8'h07) return m_cyc & 64'hFFFF_FFFF;
        for (int i = 0; i < NC; i++) begin
            if (a == 8'(8'h10 + i)) return m_cnt[i] & 64'hFFFF_FFFF;
            if (a == 8'(8'h30 + i)) return 64'({m_lng[i], 8'(m_id[i])});
        end
        return 64'd0;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h00) return "R8 control";
        if (a == 8'h01) return "R2 enable mask";
        if (a == 8'h02) return "R7 irq mask";
        if (a == 8'h03) return "R5 status";
        if (a == 8'h05) return "R12 avail";
        if (a == 8'h06) return "R13 cycle64";
        if (a == 8'h07) return "R13 cycle low";
        if (a >= 8'h30) return "R11 type";
        return "R3 counter";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit add_ovf(input longint unsigned v, input longint unsigned d, input bit lng);
        if (lng) return (v + d) < v;
        return ((v & 64'hFFFF_FFFF) + d) > 64'hFFFF_FFFF;
    endfunction

    task automatic model_step();
        longint unsigned n_cnt [NC];
        longint unsigned n_cyc, d;
        bit [31:0] set;
        int id;
        bit en;
        set = '0;
        for (int i = 0; i < NC; i++) begin
            id = m_id[i];
            d = 0;
            if (id == 0) d = (we && addr == 8'h04 && wd[i]) ? 1 : 0;
            else if (id == 17) d = 1;
            else if (id >= 1 && id <= NE) d = longint'(evt[(id-1)*EW +: EW]);
            en = m_gen && m_cen[i];
            n_cnt[i] = m_cnt[i];
            if (we && addr == 8'(8'h10 + i)) n_cnt[i] = wd;
            else if ((we && addr == 8'h00 && wd[2]) ||
                     (we && addr == 8'(8'h30 + i) && int'(wd[7:0]) != m_id[i])) n_cnt[i] = 0;
            else if (en) begin
                if (add_ovf(m_cnt[i], d, m_lng[i])) set[i] = 1'b1;
                n_cnt[i] = m_cnt[i] + d;
            end
        end
        en = m_gen && m_cen[31];
        d = (en && (!m_div || m_rem == 63)) ? 1 : 0;
        n_cyc = m_cyc;
        if (we && addr == 8'h06) n_cyc = wd;
        else if (we && addr == 8'h00 && wd[1]) n_cyc = 0;
        else if (d != 0) begin
            if (add_ovf(m_cyc, 1, m_clong)) set[31] = 1'b1;
            n_cyc = m_cyc + 1;
        end
        if (we && addr == 8'h00 && wd[3] != m_div) m_rem = 0;
        else if (en && m_div) m_rem = (m_rem + 1) % 64;
        m_ovf = (m_ovf & ~((we && addr == 8'h03) ? wd[31:0] : 32'h0)) | set;
        for (int i = 0; i < NC; i++) m_cnt[i] = n_cnt[i];
        m_cyc = n_cyc;
        if (we && addr == 8'h00) begin m_gen = wd[0]; m_div = wd[3]; m_clong = wd[4]; end
        if (we && addr == 8'h01) m_cen = wd[31:0] & okmask;
        if (we && addr == 8'h02) m_ien = wd[31:0] & okmask;
        for (int i = 0; i < NC; i++)
            if (we && addr == 8'(8'h30 + i)) begin m_id[i] = int'(wd[7:0]); m_lng[i] = wd[8]; end
    endtask

    task automatic compare_all(input string phase);
        logic [7:0] list [14] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h06, 8'h07,
                                  8'h10, 8'h11, 8'h12, 8'h13, 8'h30, 8'h31, 8'h33};
        check({phase, " R7 irq"}, 64'(irq), 64'(|(m_ovf & m_ien)));
        foreach (list[k]) begin
            addr = list[k];
            #0.01;
            check({phase, " ", tag_of(list[k])}, rd, mread(list[k]));
        end
    endtask

    task automatic tick(input logic w, input logic [7:0] a, input logic [63:0] d,
                        input logic [NE*EW-1:0] e);
        we = w; addr = a; wd = d; evt = e;
        model_step();
        @(posedge clk);
        #1;
        we = 1'b0; evt = '0;
        compare_all("clk");
    endtask

    function automatic logic [NE*EW-1:0] rnd_evt();
        seed = seed * 32'd1103515245 + 32'd12345;
        return (NE*EW)'(seed);
    endfunction

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 8'h00, 64'd0, rnd_evt());
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [63:0] exp);
        addr = a;
        #0.01;
        check(tag, rd, exp);
        check({tag, " model"}, mread(a), exp);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_cyc = 0; m_gen = 0; m_div = 0; m_clong = 0; m_cen = 0; m_ien = 0; m_ovf = 0; m_rem = 0;
        for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_id[i] = 0; m_lng[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset");
        expect_reg("R12 avail after reset", 8'h05, 64'h2_01FF);
        tick(1'b1, 8'h05, 64'hFFFF, '0);
        expect_reg("R12 read-only", 8'h05, 64'h2_01FF);

        // configuration
        tick(1'b1, 8'h30, 64'h001, '0);
        tick(1'b1, 8'h31, 64'h000, '0);
        tick(1'b1, 8'h32, 64'h011, '0);
        tick(1'b1, 8'h33, 64'h102, '0);
        tick(1'b1, 8'h01, 64'hFFFF_FFFF, '0);
        expect_reg("R2 mask bits", 8'h01, 64'h8000_000F);
        tick(1'b1, 8'h00, 64'h1, '0);
        run(40);

        // software increment
        tick(1'b1, 8'h04, 64'h3, '1);
        expect_reg("R4 swinc hit", 8'h11, mread(8'h11));
        check("R4 swinc count", 64'(m_cnt[1]), 64'd1);

        // disabled counter and unsupported id
        tick(1'b1, 8'h01, 64'h8000_000E, '0);
        run(10);
        tick(1'b1, 8'h32, 64'h020, '0);
        run(8);
        check("R3 unsupported id", 64'(m_cnt[2]), 64'd0);
        tick(1'b1, 8'h01, 64'h8000_000F, '0);

        // 32-bit overflow and interrupt
        tick(1'b1, 8'h02, 64'h8000_0009, '0);
        tick(1'b1, 8'h10, 64'hFFFF_FFF0, '0);
        tick(1'b0, 8'h00, 64'd0, '1);
        tick(1'b0, 8'h00, 64'd0, '1);
        expect_reg("R5 overflow bit0", 8'h03, mread(8'h03));
        check("R5 status set", 64'(m_ovf[0]), 64'd1);
        check("R7 irq high", 64'(irq), 64'd1);
        tick(1'b1, 8'h03, 64'h1, '0);
        check("R6 w1c", 64'(irq), 64'd0);

        // value write coinciding with an event
        tick(1'b1, 8'h10, 64'h55, '1);
        expect_reg("R10 write wins", 8'h10, 64'h55);

        // 64-bit mode on counter 3
        tick(1'b1, 8'h13, 64'h0000_0000_FFFF_FFFE, '0);
        run(4);
        check("R5 long no 32-bit flag", 64'(m_ovf[3]), 64'd0);
        tick(1'b1, 8'h13, 64'hFFFF_FFFF_FFFF_FFFE, '0);
        run(4);
        check("R13 low word only", 64'(rd >> 32), 64'd0);
        check("R5 long wrap", 64'(m_ovf[3]), 64'd1);

        // type re-selection
        tick(1'b1, 8'h10, 64'h77, '0);
        tick(1'b1, 8'h30, 64'h001, '0);
        expect_reg("R11 same id keeps", 8'h10, mread(8'h10));
        tick(1'b1, 8'h30, 64'h003, '0);
        expect_reg("R11 new id clears", 8'h10, 64'd0);

        // clears
        run(5);
        tick(1'b1, 8'h00, 64'h5, '1);
        expect_reg("R9 general clear", 8'h11, 64'd0);
        tick(1'b1, 8'h00, 64'h3, '0);
        expect_reg("R9 cycle clear", 8'h06, 64'd0);

        // divide-by-64
        tick(1'b1, 8'h00, 64'h9, '0);
        run(100);
        tick(1'b1, 8'h00, 64'h1, '0);
        tick(1'b1, 8'h00, 64'h9, '0);
        run(140);
        expect_reg("R8 div64 cycle", 8'h06, mread(8'h06));
        tick(1'b1, 8'h00, 64'h1, '0);

        // cycle counter 32-bit overflow then 64-bit read
        tick(1'b1, 8'h06, 64'hFFFF_FFFF_FFFF_FFF8, '0);
        run(12);
        check("R5 cycle overflow", 64'(m_ovf[31]), 64'd1);
        check("R7 cycle irq", 64'(irq), 64'd1);
        expect_reg("R13 cycle 64-bit", 8'h06, mread(8'h06));
        expect_reg("R13 cycle low", 8'h07, mread(8'h07));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule